// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Guard

This block decides, cycle by cycle, whether the instruction sitting in the decode stage of an in-order pipeline may issue. The pipeline feeds four execution units that finish at different times: an integer ALU, a floating-point adder, a multiplier shared by integer and floating-point multiplies, and a divider that accepts only one operation at a time. Because these units finish out of order, the guard remembers every issued result that has not yet been written back, together with its destination register and the number of cycles left before it lands.

Each cycle the decode stage presents a unit selector, an optional destination and up to two optional sources. The guard raises `stall` when any of four conditions holds: the selected unit cannot accept a new operation yet, a source is still being produced, an older slower write to the same destination would land after this one, or the single register-file write port is already taken in the cycle this instruction would write back. A stall holds only the decode stage and the stages before it. Work that has already issued keeps moving, so the stall clears on its own.

Top module: `fpu_issue_guard`

## Requirements
- R1: After reset no result is pending and no unit is busy, so any valid instruction issues with `stall` low and `stall_why` zero.
- R2: A source that matches the destination of an instruction issued k cycles earlier on a unit of latency L (ALU 0, adder 1, multiplier 4, divider 18) stalls while k <= L. The consumer issues exactly L+1 cycles after its producer.
- R3: The divider accepts a new operation no sooner than 19 cycles after the previous one. A divide presented earlier stalls with `stall_why` bit 0 set. The other units accept one operation per cycle.
- R4: An instruction whose destination matches a pending write that would land later than its own stalls with `stall_why` bit 2 set.
- R5: An instruction whose write-back would fall in the same cycle as an already issued write stalls with `stall_why` bit 3 set. The older write keeps the port.
- R6: Integer and floating-point registers with the same index are distinct. A pending write to f8 does not block a read of r8.
- R7: `stall_why` bit 1 flags a source dependency (see R2). `stall` is high exactly when `id_valid` is high and some `stall_why` bit is set. `issue` equals `id_valid` and not `stall`. With `id_valid` low, both `stall` and `stall_why` are zero.
- R8: Pending writes advance one cycle every clock, whether or not decode is stalled, so each stall ends without any instruction issuing.
- R9: A source or destination whose enable bit is low takes part in no hazard check. A disabled destination also books no write-back slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_unit | input | 2 | Target unit: 0 ALU, 1 FP adder, 2 multiplier, 3 divider |
| id_dst_en | input | 1 | Instruction writes a register |
| id_dst_fp | input | 1 | Destination is in the floating-point file |
| id_dst_idx | input | 5 | Destination register index |
| id_sa_en | input | 1 | First source is read |
| id_sa_fp | input | 1 | First source is floating-point |
| id_sa_idx | input | 5 | First source index |
| id_sb_en | input | 1 | Second source is read |
| id_sb_fp | input | 1 | Second source is floating-point |
| id_sb_idx | input | 5 | Second source index |
| stall | output | 1 | Hold decode this cycle |
| issue | output | 1 | Decode instruction leaves this cycle |
| stall_why | output | 4 | Reason bits: 0 unit busy, 1 source dependency, 2 write order, 3 write port |

## Verification
The bench uses the default parameters: latencies 0, 1, 4 and 18, and a divider interval of 19. The pending-write table is therefore 19 slots deep. At these values a divide result travels the full length of the table, so the bench can count the full 18-cycle dependency wait and the 18-cycle divider hold. With the multiplier to adder latency gap of three cycles, the bench can stage both write-order and write-port conflicts from one multiply in consecutive cycles and watch one reason hand over to the other.

// File: rtl/fpu_issue_pkg.sv
package fpu_issue_pkg;

    localparam int REG_IDX_W = 5;
    localparam int TAG_W     = REG_IDX_W + 1;
    localparam int NUM_UNITS = 4;

    localparam int DEF_LAT_ALU  = 0;
    localparam int DEF_LAT_FADD = 1;
    localparam int DEF_LAT_MUL  = 4;
    localparam int DEF_LAT_DIV  = 18;

    localparam int DEF_II_ALU  = 1;
    localparam int DEF_II_FADD = 1;
    localparam int DEF_II_MUL  = 1;
    localparam int DEF_II_DIV  = 19;

    localparam int WHY_W    = 4;
    localparam int WHY_BUSY = 0;
    localparam int WHY_RAW  = 1;
    localparam int WHY_WAW  = 2;
    localparam int WHY_PORT = 3;

    typedef enum logic [1:0] {
        UNIT_ALU  = 2'd0,
        UNIT_FADD = 2'd1,
        UNIT_MUL  = 2'd2,
        UNIT_DIV  = 2'd3
    } unit_e;

    // Register file select in the top bit keeps r<n> and f<n> apart.
    typedef struct packed {
        logic                 fp;
        logic [REG_IDX_W-1:0] idx;
    } reg_tag_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/unit_pace.sv
module unit_pace #(
    parameter int II = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int          CW     = (II > 1) ? $clog2(II) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(II - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pace_t;

    pace_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = RELOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);

endmodule

// File: rtl/wb_slot_table.sv
module wb_slot_table
    import fpu_issue_pkg::*;
#(
    parameter int TOP   = 19,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LAT_W-1:0] lat,
    input  logic             dst_en,
    input  reg_tag_t         dst_tag,
    input  logic             sa_en,
    input  reg_tag_t         sa_tag,
    input  logic             sb_en,
    input  reg_tag_t         sb_tag,
    output logic             raw_hit,
    output logic             waw_hit,
    output logic             port_hit
);
    // Slot k holds a write landing k cycles from now; slot 0 needs no storage
    // because nothing issued later can collide with or wait on it.
    typedef struct packed {
        logic     vld;
        reg_tag_t tag;
    } slot_t;

    typedef struct packed {
        slot_t [TOP:1] s;
    } tbl_t;

    tbl_t tb_d, tb_q;
    int   lat_i;

    assign lat_i = int'(lat);

    always_comb begin
        tb_d = tb_q;
        for (int k = 1; k < TOP; k++) begin
            tb_d.s[k] = tb_q.s[k+1];
        end
        tb_d.s[TOP] = '0;
        for (int k = 1; k <= TOP; k++) begin
            if (push && (lat_i == k)) begin
                tb_d.s[k].vld = 1'b1;
                tb_d.s[k].tag = dst_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '0;
        else        tb_q <= tb_d;
    end

    always_comb begin
        raw_hit  = 1'b0;
        waw_hit  = 1'b0;
        port_hit = 1'b0;
        for (int k = 1; k <= TOP; k++) begin
            if (tb_q.s[k].vld) begin
                if (sa_en && (tb_q.s[k].tag == sa_tag)) raw_hit = 1'b1;
                if (sb_en && (tb_q.s[k].tag == sb_tag)) raw_hit = 1'b1;
                if (dst_en && (tb_q.s[k].tag == dst_tag) && (k >= lat_i + 2)) waw_hit = 1'b1;
                if (dst_en && (k == lat_i + 1)) port_hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpu_issue_guard.sv
module fpu_issue_guard
    import fpu_issue_pkg::*;
#(
    parameter int LAT_ALU  = DEF_LAT_ALU,
    parameter int LAT_FADD = DEF_LAT_FADD,
    parameter int LAT_MUL  = DEF_LAT_MUL,
    parameter int LAT_DIV  = DEF_LAT_DIV,
    parameter int II_ALU   = DEF_II_ALU,
    parameter int II_FADD  = DEF_II_FADD,
    parameter int II_MUL   = DEF_II_MUL,
    parameter int II_DIV   = DEF_II_DIV
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 id_valid,
    input  logic [1:0]           id_unit,
    input  logic                 id_dst_en,
    input  logic                 id_dst_fp,
    input  logic [REG_IDX_W-1:0] id_dst_idx,
    input  logic                 id_sa_en,
    input  logic                 id_sa_fp,
    input  logic [REG_IDX_W-1:0] id_sa_idx,
    input  logic                 id_sb_en,
    input  logic                 id_sb_fp,
    input  logic [REG_IDX_W-1:0] id_sb_idx,
    output logic                 stall,
    output logic                 issue,
    output logic [WHY_W-1:0]     stall_why
);
    localparam int MAX_LAT = max_of4(LAT_ALU, LAT_FADD, LAT_MUL, LAT_DIV);
    localparam int TOP     = MAX_LAT + 1;
    localparam int LAT_W   = $clog2(TOP + 1);
    localparam int II_TAB [NUM_UNITS] = '{II_ALU, II_FADD, II_MUL, II_DIV};

    unit_e              unit_sel;
    logic [LAT_W-1:0]   lat_sel;
    logic [NUM_UNITS-1:0] unit_busy;
    reg_tag_t           dst_tag, sa_tag, sb_tag;
    logic               raw_hit, waw_hit, port_hit;
    logic               push;

    assign unit_sel = unit_e'(id_unit);
    assign dst_tag  = '{fp: id_dst_fp, idx: id_dst_idx};
    assign sa_tag   = '{fp: id_sa_fp,  idx: id_sa_idx};
    assign sb_tag   = '{fp: id_sb_fp,  idx: id_sb_idx};

    always_comb begin
        unique case (unit_sel)
            UNIT_ALU:  lat_sel = LAT_W'(LAT_ALU);
            UNIT_FADD: lat_sel = LAT_W'(LAT_FADD);
            UNIT_MUL:  lat_sel = LAT_W'(LAT_MUL);
            default:   lat_sel = LAT_W'(LAT_DIV);
        endcase
    end

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_pace
        unit_pace #(.II(II_TAB[u])) u_pace (
            .clk   (clk),
            .rst_n (rst_n),
            .start (issue && (id_unit == u[1:0])),
            .busy  (unit_busy[u])
        );
    end

    wb_slot_table #(.TOP(TOP), .LAT_W(LAT_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .lat      (lat_sel),
        .dst_en   (id_dst_en),
        .dst_tag  (dst_tag),
        .sa_en    (id_sa_en),
        .sa_tag   (sa_tag),
        .sb_en    (id_sb_en),
        .sb_tag   (sb_tag),
        .raw_hit  (raw_hit),
        .waw_hit  (waw_hit),
        .port_hit (port_hit)
    );

    always_comb begin
        stall_why           = '0;
        stall_why[WHY_BUSY] = id_valid && unit_busy[id_unit];
        stall_why[WHY_RAW]  = id_valid && raw_hit;
        stall_why[WHY_WAW]  = id_valid && waw_hit;
        stall_why[WHY_PORT] = id_valid && port_hit;
    end

    assign stall = |stall_why;
    assign issue = id_valid && !stall;
    assign push  = issue && id_dst_en;

endmodule

// File: rtl/fpu_issue_guard_chk.sv
module fpu_issue_guard_chk
    import fpu_issue_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 id_valid,
    input logic [1:0]           id_unit,
    input logic                 id_dst_en,
    input logic                 id_dst_fp,
    input logic [REG_IDX_W-1:0] id_dst_idx,
    input logic                 id_sa_en,
    input logic                 id_sa_fp,
    input logic [REG_IDX_W-1:0] id_sa_idx,
    input logic                 stall,
    input logic                 issue,
    input logic [WHY_W-1:0]     stall_why
);
    logic [1:0] arm_q;
    logic [7:0] since_div_q;
    logic       seen_div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q       <= '0;
            since_div_q <= '0;
            seen_div_q  <= 1'b0;
        end else begin
            if (arm_q != 2'd3) arm_q <= arm_q + 1'b1;
            if (issue && (id_unit == UNIT_DIV)) begin
                since_div_q <= 8'd1;
                seen_div_q  <= 1'b1;
            end else if (since_div_q != 8'hFF) begin
                since_div_q <= since_div_q + 1'b1;
            end
        end
    end

    a_r7_issue_clean: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (id_valid && !stall));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!stall && (stall_why == '0)));

    a_r3_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (id_unit == UNIT_DIV) && seen_div_q) |-> (since_div_q >= 8'(DEF_II_DIV)));

    a_r2_fadd_consumer: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (id_unit == UNIT_FADD) && id_dst_en) |=>
        (!(id_valid && id_sa_en && ({id_sa_fp, id_sa_idx} == $past({id_dst_fp, id_dst_idx}))) || stall));

    a_r4_mul_then_fadd: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (id_unit == UNIT_MUL) && id_dst_en) |=>
        (!(id_valid && (id_unit == UNIT_FADD) && id_dst_en &&
           ({id_dst_fp, id_dst_idx} == $past({id_dst_fp, id_dst_idx}))) || stall));

    if (DEF_LAT_MUL - DEF_LAT_FADD == 3) begin : g_port
        a_r5_port_owner: assert property (@(posedge clk) disable iff (!rst_n)
            ((arm_q == 2'd3) && issue && (id_unit == UNIT_FADD) && id_dst_en) |->
            !$past(issue && (id_unit == UNIT_MUL) && id_dst_en, 3));
    end

endmodule

bind fpu_issue_guard fpu_issue_guard_chk u_chk (.*);

// File: tb/fpu_issue_guard_test.sv
`timescale 1ns/1ps
module fpu_issue_guard_test;
    import fpu_issue_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_valid = 1'b0;
    logic [1:0] id_unit = '0;
    logic       id_dst_en = 1'b0, id_dst_fp = 1'b0;
    logic [4:0] id_dst_idx = '0;
    logic       id_sa_en = 1'b0, id_sa_fp = 1'b0;
    logic [4:0] id_sa_idx = '0;
    logic       id_sb_en = 1'b0, id_sb_fp = 1'b0;
    logic [4:0] id_sb_idx = '0;
    logic       stall, issue;
    logic [3:0] stall_why;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    fpu_issue_guard uut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_unit(id_unit),
        .id_dst_en(id_dst_en), .id_dst_fp(id_dst_fp), .id_dst_idx(id_dst_idx),
        .id_sa_en(id_sa_en), .id_sa_fp(id_sa_fp), .id_sa_idx(id_sa_idx),
        .id_sb_en(id_sb_en), .id_sb_fp(id_sb_fp), .id_sb_idx(id_sb_idx),
        .stall(stall), .issue(issue), .stall_why(stall_why)
    );

    // tag = {fp, idx[4:0]}; why = {port, waw, raw, busy}
    typedef struct packed {
        logic       vld;
        logic [1:0] unit;
        logic       de;
        logic [5:0] dt;
        logic       ae;
        logic [5:0] at;
        logic       be;
        logic [5:0] bt;
        logic [3:0] why;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 1'b1, 6'h01, 1'b1, 6'h02, 1'b1, 6'h03, 4'b0000}, // 0 ALU r1
        '{1'b1, 2'd0, 1'b1, 6'h04, 1'b1, 6'h00, 1'b1, 6'h01, 4'b0000}, // 1 R2 ALU lat 0
        '{1'b1, 2'd1, 1'b1, 6'h22, 1'b1, 6'h20, 1'b1, 6'h24, 4'b0000}, // 2 FADD f2
        '{1'b1, 2'd1, 1'b1, 6'h26, 1'b1, 6'h22, 1'b0, 6'h00, 4'b0010}, // 3 R2 raw f2
        '{1'b1, 2'd1, 1'b1, 6'h26, 1'b1, 6'h22, 1'b0, 6'h00, 4'b0000}, // 4 R8 clears
        '{1'b1, 2'd2, 1'b1, 6'h28, 1'b1, 6'h2A, 1'b0, 6'h00, 4'b0000}, // 5 MUL f8
        '{1'b1, 2'd0, 1'b1, 6'h05, 1'b1, 6'h08, 1'b0, 6'h00, 4'b0000}, // 6 R6 r8 vs f8
        '{1'b1, 2'd1, 1'b1, 6'h2C, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0000}, // 7 FADD f12
        '{1'b1, 2'd1, 1'b1, 6'h2D, 1'b0, 6'h00, 1'b0, 6'h00, 4'b1000}, // 8 R5 port
        '{1'b1, 2'd1, 1'b1, 6'h2D, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0000}, // 9
        '{1'b1, 2'd2, 1'b1, 6'h2E, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0000}, // 10 MUL f14
        '{1'b1, 2'd1, 1'b1, 6'h2E, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0100}, // 11 R4 waw
        '{1'b1, 2'd1, 1'b1, 6'h2E, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0100}, // 12 R4 waw
        '{1'b1, 2'd1, 1'b1, 6'h2E, 1'b0, 6'h00, 1'b0, 6'h00, 4'b1000}, // 13 R5 port
        '{1'b1, 2'd1, 1'b1, 6'h2E, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0000}, // 14
        '{1'b1, 2'd3, 1'b1, 6'h30, 1'b1, 6'h20, 1'b0, 6'h00, 4'b0000}, // 15 DIV f16
        '{1'b1, 2'd3, 1'b1, 6'h32, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0001}, // 16 R3 busy
        '{1'b1, 2'd0, 1'b1, 6'h30, 1'b1, 6'h30, 1'b0, 6'h00, 4'b0110}, // 17 raw+waw
        '{1'b0, 2'd0, 1'b1, 6'h30, 1'b1, 6'h30, 1'b0, 6'h00, 4'b0000}, // 18 R7 idle
        '{1'b1, 2'd0, 1'b1, 6'h07, 1'b1, 6'h02, 1'b1, 6'h30, 4'b0010}, // 19 raw on b
        '{1'b1, 2'd0, 1'b1, 6'h07, 1'b0, 6'h30, 1'b0, 6'h00, 4'b0000}, // 20 R9 src off
        '{1'b1, 2'd1, 1'b0, 6'h30, 1'b0, 6'h00, 1'b0, 6'h00, 4'b0000}  // 21 R9 dst off
    };

    task automatic apply(input vec_t v);
        id_valid  = v.vld;
        id_unit   = v.unit;
        id_dst_en = v.de;  {id_dst_fp, id_dst_idx} = v.dt;
        id_sa_en  = v.ae;  {id_sa_fp, id_sa_idx}   = v.at;
        id_sb_en  = v.be;  {id_sb_fp, id_sb_idx}   = v.bt;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic vec_t mk(input logic [1:0] u, input logic [5:0] d,
                                input logic ae, input logic [5:0] a);
        vec_t v;
        v = '0;
        v.vld = 1'b1; v.unit = u; v.de = 1'b1; v.dt = d; v.ae = ae; v.at = a;
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        id_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Holds v in decode until it issues; returns the number of stalled cycles.
    task automatic hold(input vec_t v, output int n);
        n = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            apply(v);
            #1;
            if (issue) break;
            n++;
        end
    endtask

    task automatic one(input vec_t v);
        @(negedge clk);
        apply(v);
        #1;
    endtask

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        // R1: during and after reset
        repeat (2) @(negedge clk);
        #1;
        check("R1 stall in reset", int'(stall), 0);
        check("R1 issue in reset", int'(issue), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VEC[i]);
            #1;
            check($sformatf("R7 vec%0d stall_why", i), int'(stall_why), int'(VEC[i].why));
            check($sformatf("R7 vec%0d issue", i), int'(issue),
                  int'(VEC[i].vld && (VEC[i].why == 4'b0000)));
        end

        // R1: reset clears pending f16 and the busy divider
        do_reset();
        one(mk(2'd3, 6'h30, 1'b1, 6'h30));
        check("R1 post reset why", int'(stall_why), 0);
        check("R1 post reset issue", int'(issue), 1);

        // R3: divider pacing, 18 held cycles
        do_reset();
        one(mk(2'd3, 6'h21, 1'b0, 6'h00));
        check("R3 first div issue", int'(issue), 1);
        hold(mk(2'd3, 6'h23, 1'b0, 6'h00), n);
        check("R3 div hold cycles", n, 18);

        // R2: consumer of a divide waits its 18-cycle latency
        do_reset();
        one(mk(2'd3, 6'h21, 1'b0, 6'h00));
        hold(mk(2'd1, 6'h25, 1'b1, 6'h21), n);
        check("R2 div consumer wait", n, 18);

        // R2/R8: consumer of a multiply waits 4 cycles
        do_reset();
        one(mk(2'd2, 6'h21, 1'b0, 6'h00));
        hold(mk(2'd0, 6'h02, 1'b1, 6'h21), n);
        check("R2 mul consumer wait", n, 4);

        @(negedge clk);
        id_valid = 1'b0;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule